// File: doc/BRIEF.md
# Word-protecting ECC controller with byte read-modify-write

This block sits between a byte-wide request port and a storage array that holds 32-bit words. It stores each word as a 38-bit codeword: the 32 data bits plus 6 Hamming check bits. Reads go through a corrector that repairs any single flipped bit of the stored codeword before a byte is returned. A byte write cannot update one byte alone, because the check bits cover all four bytes together. Every byte write therefore reads the whole word, corrects it, replaces one byte lane, re-encodes the result and writes back all 38 bits.

After reset the block fills the array with all-ones data bytes and their matching check bits. Only then does it accept requests. It handles one request at a time and signals completion with a one-cycle `done` pulse.

The controller is one state machine. S_INIT writes one word per cycle and goes to S_IDLE after the last word. S_IDLE moves to S_READ when a request is accepted. S_READ issues the array read and always moves to S_FIX. S_FIX captures the corrected word. From S_FIX a read goes to S_DONE and a write goes to S_MERGE. S_MERGE goes to S_WRITE, S_WRITE goes to S_DONE, and S_DONE always returns to S_IDLE. The array has a one-cycle read latency: `mem_rdata` is valid in the cycle after the one in which `mem_rd` is high.

Top module: `ecc_byte_rmw`

## Requirements
- R1: While reset is active and after it is released, `ready` stays low while the block writes every word address once, in ascending order and one per cycle. Each word is written with data FFFFFFFFh and its check bits. `ready` then goes high, and reading any byte returns FFh with `corrected` low.
- R2: Codeword layout: bit index p-1 holds codeword position p, for p = 1..38. Positions 1, 2, 4, 8, 16 and 32 hold check bits. Data bits 0..31 fill the other positions in ascending order (data bit 0 at position 3, data bit 1 at position 5, and so on). Check bit 2^k is the even parity of all data positions whose number has bit k set. Every codeword the block writes follows this layout.
- R3: A request is accepted at a rising edge where `req_valid` and `ready` are both high. `mem_rd` is high in the next cycle. For a read, `done` is high in the third cycle after the accept edge. `rdata` then carries byte lane `req_addr[1:0]` of the word, where lane 0 is data bits 7:0.
- R4: If exactly one bit of a stored codeword is flipped, at any position 1..38, the byte returned by a read is the value originally written.
- R5: A byte write reads the word, corrects it, and replaces lane `req_addr[1:0]` with `req_wdata`. It keeps the other three lanes, including any corrected bit. It writes the full 38-bit codeword back to the same word address, and `done` is high in the fifth cycle after the accept edge. The stored word therefore ends up error-free.
- R6: `corrected` is high only while `done` is high, and only when the syndrome pointed at a bit that was flipped. A clean word leaves it low.
- R7: `done` lasts one cycle, and `ready` is low from the accept edge until `done` has been seen. A request presented while `ready` is low is ignored and leaves the array untouched.
- R8: `mem_rd` and `mem_we` are never high together, and a read request never writes the array.
- R9: A syndrome value outside 1..38 (for example 39, which two flipped bits can produce) changes no bit. The returned byte is taken from the raw stored data bits, and `corrected` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address; bits 1:0 select the lane |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read from the addressed lane, valid with done |
| corrected | output | 1 | A bit was repaired in this request's word, valid with done |
| mem_addr | output | ADDR_W-2 | Word address toward the array |
| mem_rd | output | 1 | Array read strobe |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 38 | Codeword to store |
| mem_rdata | input | 38 | Codeword read, valid the cycle after mem_rd |

## Verification
The bench builds the block with ADDR_W = 6, which gives 16 words and 64 byte addresses. At this size every byte address can be written and read back, and every one of the 38 codeword positions can be flipped in turn in one stored word. Each flip is followed by a read and by a repairing byte write. The bench's array model injects the flips directly. A two-bit corruption that produces syndrome 39 and a request issued while the block is busy cover the remaining corner cases.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int LANES  = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [2:0] {
        S_INIT,
        S_IDLE,
        S_READ,
        S_FIX,
        S_MERGE,
        S_WRITE,
        S_DONE
    } ctl_state_t;

    // position p (1-based) carries a check bit when p is a power of two
    function automatic logic is_check_pos(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    // scatter data bits over the non-check positions, check slots left zero
    function automatic code_t spread_data(input word_t d);
        code_t c;
        int    j;
        c = '0;
        j = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                c[p-1] = d[j];
                j++;
            end
        end
        return c;
    endfunction

    // gather data bits back from the non-check positions
    function automatic word_t gather_data(input code_t c);
        word_t d;
        int    j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                d[j] = c[p-1];
                j++;
            end
        end
        return d;
    endfunction

    // XOR of the position numbers of all set bits
    function automatic syn_t code_syndrome(input code_t c);
        syn_t s;
        s = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (c[p-1]) s = s ^ CHK_W'(p);
        end
        return s;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_pkg::*;
(
    input  word_t data_in,
    output code_t code_out
);

    code_t base;
    code_t chk_vec;
    syn_t  base_syn;

    assign base     = spread_data(data_in);
    assign base_syn = code_syndrome(base);

    // each power-of-two slot takes the syndrome bit that names it
    for (genvar i = 0; i < CODE_W; i++) begin : g_slot
        if (((i + 1) & i) == 0) begin : g_chk
            assign chk_vec[i] = base_syn[$clog2(i + 1)];
        end else begin : g_dat
            assign chk_vec[i] = 1'b0;
        end
    end

    assign code_out = base | chk_vec;

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_pkg::*;
(
    input  code_t code_in,
    output word_t data_out,
    output logic  fixed
);

    syn_t  syn;
    code_t flip_mask;

    assign syn = code_syndrome(code_in);

    // one decoder line per codeword position; out-of-range syndromes hit none
    for (genvar i = 0; i < CODE_W; i++) begin : g_hit
        assign flip_mask[i] = (syn == CHK_W'(i + 1));
    end

    assign fixed    = |flip_mask;
    assign data_out = gather_data(code_in ^ flip_mask);

endmodule

// File: rtl/ecc_byte_rmw.sv
module ecc_byte_rmw
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              ready,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              corrected,
    output logic [ADDR_W-3:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [37:0]       mem_wdata,
    input  logic [37:0]       mem_rdata
);

    localparam int WORD_AW   = ADDR_W - 2;
    localparam int NUM_WORDS = 1 << WORD_AW;
    localparam logic [WORD_AW-1:0] LAST_WORD = WORD_AW'(NUM_WORDS - 1);

    ctl_state_t          state, state_nx;
    logic [WORD_AW-1:0]  fill_idx;
    logic [ADDR_W-1:0]   addr_q;
    logic                wr_q;
    logic [7:0]          wbyte_q;
    word_t               word_q;
    logic                fix_q;

    word_t               enc_in;
    code_t               enc_out;
    word_t               dec_data;
    logic                dec_fixed;

    ecc_enc u_enc (
        .data_in  (enc_in),
        .code_out (enc_out)
    );

    ecc_dec u_dec (
        .code_in  (mem_rdata),
        .data_out (dec_data),
        .fixed    (dec_fixed)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_INIT;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_INIT:  if (fill_idx == LAST_WORD) state_nx = S_IDLE;
            S_IDLE:  if (req_valid)             state_nx = S_READ;
            S_READ:                             state_nx = S_FIX;
            S_FIX:   state_nx = wr_q ? S_MERGE : S_DONE;
            S_MERGE:                            state_nx = S_WRITE;
            S_WRITE:                            state_nx = S_DONE;
            S_DONE:                             state_nx = S_IDLE;
            default:                            state_nx = S_INIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_idx <= '0;
            addr_q   <= '0;
            wr_q     <= 1'b0;
            wbyte_q  <= '0;
            word_q   <= '0;
            fix_q    <= 1'b0;
        end else begin
            unique case (state)
                S_INIT: fill_idx <= fill_idx + 1'b1;
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wr_q    <= req_write;
                        wbyte_q <= req_wdata;
                        fix_q   <= 1'b0;
                    end
                end
                S_FIX: begin
                    word_q <= dec_data;
                    fix_q  <= dec_fixed;
                end
                S_MERGE: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (addr_q[1:0] == 2'(l)) word_q[l*8 +: 8] <= wbyte_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign enc_in = (state == S_INIT) ? '1 : word_q;

    // outputs
    always_comb begin
        ready     = 1'b0;
        done      = 1'b0;
        corrected = 1'b0;
        rdata     = word_q[addr_q[1:0]*8 +: 8];
        mem_addr  = addr_q[ADDR_W-1:2];
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = enc_out;
        unique case (state)
            S_INIT: begin
                mem_addr = fill_idx;
                mem_we   = 1'b1;
            end
            S_IDLE:  ready  = 1'b1;
            S_READ:  mem_rd = 1'b1;
            S_WRITE: mem_we = 1'b1;
            S_DONE: begin
                done      = 1'b1;
                corrected = fix_q;
            end
            default: ;
        endcase
    end

    // assertions
    a_r1_init_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INIT) |-> (gather_data(mem_wdata) == '1));

    a_r3_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> mem_rd);

    a_r5_writeback_carries_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |-> (gather_data(mem_wdata) == word_q));

    a_r6_flag_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        corrected |-> done);

    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

endmodule

// File: tb/ecc_byte_rmw_tb.sv
module ecc_byte_rmw_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int NW         = 1 << (ADDR_W - 2);
    localparam int NB         = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              ready, done, corrected;
    logic [7:0]        rdata;
    logic [ADDR_W-3:0] mem_addr;
    logic              mem_rd, mem_we;
    logic [37:0]       mem_wdata;
    logic [37:0]       rd_q = '0;

    logic [37:0]       store [NW];
    logic [7:0]        shadow [NB];
    int                we_cnt = 0;
    int                n_checks = 0;
    int                n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_byte_rmw #(.ADDR_W(ADDR_W)) u_dut (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .ready, .done, .rdata, .corrected,
        .mem_addr, .mem_rd, .mem_we, .mem_wdata, .mem_rdata(rd_q)
    );

    // array model, one cycle read latency
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            store[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_rd) rd_q <= store[mem_addr];
    end

    function automatic logic [37:0] tb_enc(input logic [31:0] w);
        logic [37:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = w[j];
                j++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= 38; p++) begin
                if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0) par = par ^ c[p-1];
            end
            c[(1 << k) - 1] = par;
        end
        return c;
    endfunction

    function automatic logic [31:0] tb_raw(input logic [37:0] c);
        logic [31:0] w;
        int j;
        w = '0;
        j = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[j] = c[p-1];
                j++;
            end
        end
        return w;
    endfunction

    function automatic logic [31:0] shadow_word(input int w);
        return {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                           output logic [7:0] rb, output bit fl, output int lat);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        rb = rdata;
        fl = corrected;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        bit fl;
        int lat;
        int we0;
        logic [37:0] bad;

        // R1: reset and fill
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R1", "ready in reset", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b0, "R1", "ready during fill", ready, 0);
        while (!ready) @(negedge clk);
        check(we_cnt == NW, "R1", "fill write count", we_cnt, NW);
        for (int w = 0; w < NW; w++)
            check(store[w] == tb_enc(32'hFFFF_FFFF), "R2", "fill codeword", store[w], tb_enc(32'hFFFF_FFFF));

        // R1/R3: erased reads
        for (int a = 0; a < NB; a++) begin
            we0 = we_cnt;
            run_req(1'b0, ADDR_W'(a), 8'h00, rb, fl, lat);
            check(rb == 8'hFF, "R1", "erased byte", rb, 8'hFF);
            check(fl == 1'b0, "R6", "flag on clean read", fl, 0);
            check(lat == 3, "R3", "read latency", lat, 3);
            check(we_cnt == we0, "R8", "read wrote array", we_cnt, we0);
        end

        // R5: write every byte with a distinct pattern
        for (int a = 0; a < NB; a++) begin
            shadow[a] = 8'((a * 37 + 5) & 8'hFF);
            run_req(1'b1, ADDR_W'(a), shadow[a], rb, fl, lat);
            check(lat == 5, "R5", "write latency", lat, 5);
        end
        for (int w = 0; w < NW; w++)
            check(store[w] == tb_enc(shadow_word(w)), "R2", "stored codeword", store[w], tb_enc(shadow_word(w)));
        for (int a = 0; a < NB; a++) begin
            run_req(1'b0, ADDR_W'(a), 8'h00, rb, fl, lat);
            check(rb == shadow[a], "R3", "lane readback", rb, shadow[a]);
        end

        // R4/R6/R5: flip every position of word 3, read, then repair by writing
        for (int p = 1; p <= 38; p++) begin
            @(negedge clk);
            bad = store[3] ^ (38'd1 << (p - 1));
            store[3] = bad;
            run_req(1'b0, ADDR_W'(12 + (p % 4)), 8'h00, rb, fl, lat);
            check(rb == shadow[12 + (p % 4)], "R4", "corrected byte", rb, shadow[12 + (p % 4)]);
            check(fl == 1'b1, "R6", "flag on repair", fl, 1);
            check(store[3] == bad, "R8", "read left word", store[3], bad);
            shadow[12 + ((p + 1) % 4)] = 8'((p * 7) & 8'hFF);
            run_req(1'b1, ADDR_W'(12 + ((p + 1) % 4)), shadow[12 + ((p + 1) % 4)], rb, fl, lat);
            check(fl == 1'b1, "R5", "flag on rmw repair", fl, 1);
            check(store[3] == tb_enc(shadow_word(3)), "R5", "repaired word", store[3], tb_enc(shadow_word(3)));
        end

        // R9: two flips giving syndrome 39
        @(negedge clk);
        bad = store[5] ^ (38'd1 << 31) ^ (38'd1 << 6);
        store[5] = bad;
        run_req(1'b0, ADDR_W'(20), 8'h00, rb, fl, lat);
        check(rb == tb_raw(bad)[7:0], "R9", "raw byte", rb, tb_raw(bad)[7:0]);
        check(fl == 1'b0, "R9", "no flag", fl, 0);

        // R7: request while busy is ignored
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = ADDR_W'(40);
        req_wdata = 8'h5A;
        shadow[40] = 8'h5A;
        @(negedge clk);
        req_addr  = ADDR_W'(8);
        req_wdata = 8'h11;
        check(ready == 1'b0, "R7", "ready while busy", ready, 0);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        check(done == 1'b0, "R7", "done width", done, 0);
        run_req(1'b0, ADDR_W'(8), 8'h00, rb, fl, lat);
        check(rb == shadow[8], "R7", "ignored write", rb, shadow[8]);
        run_req(1'b0, ADDR_W'(40), 8'h00, rb, fl, lat);
        check(rb == 8'h5A, "R7", "accepted write", rb, 8'h5A);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule